// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

The controller runs thirteen general-purpose pins. It sits behind a simple synchronous register bus that carries an address, write data, a write strobe, a read strobe and read data. Each pin has two byte-wide registers.

The output-control byte of a pin sets the following:
- direction;
- push-pull or open-drain drive;
- a pull-resistor enable and selection, which is only exported as configuration bits;
- the driven value.

The input-control byte of a pin does two things:
- it selects which edges of the synchronized pin level raise an interrupt;
- it reads back that level in bit 0.

Pins are split into interrupt groups of seven (pins 0–6) and six (pins 7–12). Each group has a sticky status register and a mask register. Status bits are cleared by writing one to them. A single interrupt line is the OR of every pending status bit whose mask bit is clear. Software reads the two status bytes back to back and joins them as `{group1[5:0], group0[6:0]}` to get a pending vector indexed by pin number.

Top module: `gpc_top`

## Requirements
- R1: After reset every output-control byte reads 0x00, so all pins are open-drain inputs with `pin_oe` low. Every detect mode is off. Both status registers read 0. The mask registers read 0x7F (group 0) and 0x3F (group 1), and `irq` is low.
- R2: The output-control byte of pin p is at address 0x4E44+p. Its fields are: bit 5 direction (1 = output), bit 4 drive (1 = push-pull, 0 = open-drain), bit 3 pull enable, bits 2:1 pull select (0 = 2k down, 1 = 2k up, 2 = 50k down, 3 = 50k up) and bit 0 output value. The fields appear on `drive_pp[p]`, `pull_en[p]`, `pull_sel[2p+1:2p]` and `pin_out[p]` right after the write, and bits 7:6 read as 0.
- R3: In push-pull drive, `pin_oe[p]` equals the direction bit. In open-drain drive, `pin_oe[p]` is high only when the pin is an output whose value bit is 0.
- R4: The input-control byte of pin p is at address 0x4E51+p. Bit 0 reads the pin level after a two-flop synchronizer, and writes to bit 0 are ignored. Bits 2:1 hold the detect mode and read back as written. All other bits read 0.
- R5: Detect mode 1 flags falling edges, mode 2 flags rising edges and mode 3 flags both edges. Mode 0 flags none.
- R6: The status for pin n < 7 is bit n of address 0x4E0B. The status for pin n ≥ 7 is bit n−7 of address 0x4E0C. The masks follow the same bit layout at 0x4E19 and 0x4E1A. Bits above the group width read 0.
- R7: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. If an edge arrives in the same cycle as a clear, the bit stays set.
- R8: A detected edge sets its status bit whether or not the pin is masked. A mask bit of 1 blocks that pin from `irq` and a 0 passes it. `irq` stays high until every unmasked pending bit has been cleared.
- R9: A read of any unmapped address returns 0, and a write to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, registered on the read strobe |
| pin_in | input | 13 | Pad input levels |
| pin_out | output | 13 | Pad output values |
| pin_oe | output | 13 | Pad output enables |
| drive_pp | output | 13 | 1 = push-pull, 0 = open-drain |
| pull_en | output | 13 | Pull-resistor enables |
| pull_sel | output | 26 | Pull select, two bits per pin |
| irq | output | 1 | Combined interrupt |

## Verification
Each result has a fixed latency, and every check waits at least that long before it samples:
- Configuration outputs follow a register write as soon as the write edge has passed.
- Read data appears one clock edge after the read strobe, so the bench samples it at the next falling edge.
- A pin change reaches the synchronized level two edges later and sets the status bit on the third edge. The bench therefore waits five cycles after changing a pin before it reads the level or the status.
- The test of a clear that coincides with an edge places the write strobe on exactly that third edge.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
    localparam int PIN_COUNT  = 13;
    localparam int GRP0_COUNT = 7;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;

    localparam logic [ADDR_W-1:0] OUT_BASE  = 16'h4E44;
    localparam logic [ADDR_W-1:0] IN_BASE   = 16'h4E51;
    localparam logic [ADDR_W-1:0] STAT_BASE = 16'h4E0B;
    localparam logic [ADDR_W-1:0] MASK_BASE = 16'h4E19;

    typedef enum logic [1:0] {
        DET_OFF  = 2'd0,
        DET_FALL = 2'd1,
        DET_RISE = 2'd2,
        DET_BOTH = 2'd3
    } det_mode_t;

    // Field order matches the byte layout, bit 5 down to bit 0
    typedef struct packed {
        logic       dir;
        logic       push_pull;
        logic       pull_en;
        logic [1:0] pull_sel;
        logic       level;
    } outctl_t;

    function automatic logic edge_hit(det_mode_t m, logic now, logic prev);
        case (m)
            DET_FALL: edge_hit = prev & ~now;
            DET_RISE: edge_hit = now & ~prev;
            DET_BOTH: edge_hit = now ^ prev;
            default:  edge_hit = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/gpc_pin_cell.sv
module gpc_pin_cell
    import gpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_in,
    input  logic       wr_out,
    input  logic       wr_in,
    input  logic [5:0] wdata,
    output outctl_t    ctl,
    output det_mode_t  det,
    output logic       level,
    output logic       edge_pulse,
    output logic       pad_out,
    output logic       pad_oe
);
    logic sync1, sync2, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            prev  <= 1'b0;
            ctl   <= '0;
            det   <= DET_OFF;
        end else begin
            sync1 <= pin_in;
            sync2 <= sync1;
            prev  <= sync2;
            if (wr_out) ctl <= outctl_t'(wdata);
            if (wr_in)  det <= det_mode_t'(wdata[2:1]);
        end
    end

    assign level      = sync2;
    assign edge_pulse = edge_hit(det, sync2, prev);
    assign pad_out    = ctl.level;
    assign pad_oe     = ctl.dir & (ctl.push_pull | ~ctl.level);

    // R3: an enabled pad is always an output
    assert_oe_needs_dir_R3: assert property (@(posedge clk) disable iff (rst)
        pad_oe |-> ctl.dir);
    // R3: open-drain never drives a high value
    assert_od_no_high_R3: assert property (@(posedge clk) disable iff (rst)
        (!ctl.push_pull && pad_out) |-> !pad_oe);
endmodule

// File: rtl/gpc_irq_group.sv
module gpc_irq_group #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] edge_in,
    input  logic         wr_stat,
    input  logic         wr_mask,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] status,
    output logic [W-1:0] mask,
    output logic         pend
);
    logic [W-1:0] clr;

    assign clr = wr_stat ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= '1;
        end else begin
            status <= (status & ~clr) | edge_in;
            if (wr_mask) mask <= wdata;
        end
    end

    assign pend = |(status & ~mask);

    for (genvar i = 0; i < W; i++) begin : g_chk
        // R7: an edge always lands, even against a clear
        assert_edge_sets_R7: assert property (@(posedge clk) disable iff (rst)
            edge_in[i] |=> status[i]);
        // R8: a set bit leaves only by a write of one, never through the mask
        assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
            (status[i] && !(wr_stat && wdata[i])) |=> status[i]);
    end
endmodule

// File: rtl/gpc_top.sv
module gpc_top
    import gpc_pkg::*;
#(
    parameter int N_PINS = PIN_COUNT,
    parameter int N_GRP0 = GRP0_COUNT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_wr,
    input  logic                bus_rd,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [N_PINS-1:0]   pin_in,
    output logic [N_PINS-1:0]   pin_out,
    output logic [N_PINS-1:0]   pin_oe,
    output logic [N_PINS-1:0]   drive_pp,
    output logic [N_PINS-1:0]   pull_en,
    output logic [2*N_PINS-1:0] pull_sel,
    output logic                irq
);
    localparam int N_GRP1 = N_PINS - N_GRP0;

    outctl_t     ctl_q [N_PINS];
    det_mode_t   det_q [N_PINS];
    logic [N_PINS-1:0] lvl, edges, wr_out, wr_in;
    logic [N_GRP0-1:0] st0, mk0;
    logic [N_GRP1-1:0] st1, mk1;
    logic        pend0, pend1;
    logic [DATA_W-1:0] rd_next;
    logic        rd_hit;
    logic        unused_hi;

    assign unused_hi = ^bus_wdata[DATA_W-1:N_GRP0];

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        assign wr_out[p] = bus_wr && (bus_addr == OUT_BASE + ADDR_W'(p));
        assign wr_in[p]  = bus_wr && (bus_addr == IN_BASE + ADDR_W'(p));

        gpc_pin_cell u_cell (
            .clk        (clk),
            .rst        (rst),
            .pin_in     (pin_in[p]),
            .wr_out     (wr_out[p]),
            .wr_in      (wr_in[p]),
            .wdata      (bus_wdata[5:0]),
            .ctl        (ctl_q[p]),
            .det        (det_q[p]),
            .level      (lvl[p]),
            .edge_pulse (edges[p]),
            .pad_out    (pin_out[p]),
            .pad_oe     (pin_oe[p])
        );

        assign drive_pp[p]       = ctl_q[p].push_pull;
        assign pull_en[p]        = ctl_q[p].pull_en;
        assign pull_sel[2*p +: 2] = ctl_q[p].pull_sel;
    end

    gpc_irq_group #(.W(N_GRP0)) u_grp0 (
        .clk     (clk),
        .rst     (rst),
        .edge_in (edges[N_GRP0-1:0]),
        .wr_stat (bus_wr && bus_addr == STAT_BASE),
        .wr_mask (bus_wr && bus_addr == MASK_BASE),
        .wdata   (bus_wdata[N_GRP0-1:0]),
        .status  (st0),
        .mask    (mk0),
        .pend    (pend0)
    );

    gpc_irq_group #(.W(N_GRP1)) u_grp1 (
        .clk     (clk),
        .rst     (rst),
        .edge_in (edges[N_PINS-1:N_GRP0]),
        .wr_stat (bus_wr && bus_addr == STAT_BASE + ADDR_W'(1)),
        .wr_mask (bus_wr && bus_addr == MASK_BASE + ADDR_W'(1)),
        .wdata   (bus_wdata[N_GRP1-1:0]),
        .status  (st1),
        .mask    (mk1),
        .pend    (pend1)
    );

    assign irq = pend0 | pend1;

    always_comb begin
        rd_next = '0;
        rd_hit  = 1'b0;
        for (int p = 0; p < N_PINS; p++) begin
            if (bus_addr == OUT_BASE + ADDR_W'(p)) begin
                rd_next = DATA_W'(ctl_q[p]);
                rd_hit  = 1'b1;
            end
            if (bus_addr == IN_BASE + ADDR_W'(p)) begin
                rd_next = DATA_W'({det_q[p], lvl[p]});
                rd_hit  = 1'b1;
            end
        end
        if (bus_addr == STAT_BASE) begin
            rd_next = DATA_W'(st0);
            rd_hit  = 1'b1;
        end
        if (bus_addr == STAT_BASE + ADDR_W'(1)) begin
            rd_next = DATA_W'(st1);
            rd_hit  = 1'b1;
        end
        if (bus_addr == MASK_BASE) begin
            rd_next = DATA_W'(mk0);
            rd_hit  = 1'b1;
        end
        if (bus_addr == MASK_BASE + ADDR_W'(1)) begin
            rd_next = DATA_W'(mk1);
            rd_hit  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

    // R9: unmapped reads return zero
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !rd_hit) |=> (bus_rdata == '0));
    // R8: the line never rises without some pending status
    assert_irq_has_source_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|{st1, st0}));
endmodule

// File: tb/gpc_top_test.sv
module gpc_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [12:0] pin_in = '0;
    logic [12:0] pin_out, pin_oe, drive_pp, pull_en;
    logic [25:0] pull_sel;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    gpc_top uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .drive_pp(drive_pp), .pull_en(pull_en), .pull_sel(pull_sel), .irq(irq)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pin_in = '0; bus_wr = 0; bus_rd = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic set_pin(int p, logic v);
        @(negedge clk);
        pin_in[p] = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        chk("R1", "pin_oe", 32'(pin_oe), 0);
        chk("R1", "irq", 32'(irq), 0);
        rd(16'h4E19, v); chk("R1", "mask0", 32'(v), 32'h7F);
        rd(16'h4E1A, v); chk("R1", "mask1", 32'(v), 32'h3F);
        rd(16'h4E0B, v); chk("R1", "stat0", 32'(v), 0);
        rd(16'h4E0C, v); chk("R1", "stat1", 32'(v), 0);
        rd(16'h4E44, v); chk("R1", "outctl0", 32'(v), 0);
        rd(16'h4E5D, v); chk("R1", "inctl12", 32'(v), 0);
    endtask

    task automatic t_outctl();
        logic [7:0] v;
        do_reset();
        wr(16'h4E47, 8'h3F);
        rd(16'h4E47, v); chk("R2", "readback", 32'(v), 32'h3F);
        chk("R2", "pin_out3", 32'(pin_out[3]), 1);
        chk("R2", "pull_en3", 32'(pull_en[3]), 1);
        chk("R2", "pull_sel3", 32'(pull_sel[7:6]), 3);
        chk("R2", "drive_pp3", 32'(drive_pp[3]), 1);
        wr(16'h4E47, 8'hCA);
        rd(16'h4E47, v); chk("R2", "top bits zero", 32'(v), 32'h0A);
        chk("R2", "pull_sel3 b", 32'(pull_sel[7:6]), 1);
        chk("R2", "pin_out3 b", 32'(pin_out[3]), 0);
    endtask

    task automatic t_oe();
        do_reset();
        wr(16'h4E49, 8'h31); chk("R3", "pp out hi", 32'(pin_oe[5]), 1);
        wr(16'h4E49, 8'h21); chk("R3", "od out hi", 32'(pin_oe[5]), 0);
        wr(16'h4E49, 8'h20); chk("R3", "od out lo", 32'(pin_oe[5]), 1);
        wr(16'h4E49, 8'h11); chk("R3", "pp input", 32'(pin_oe[5]), 0);
        chk("R3", "others off", 32'(pin_oe & ~13'h20), 0);
    endtask

    task automatic t_level();
        logic [7:0] v;
        do_reset();
        set_pin(9, 1'b1);
        rd(16'h4E5A, v); chk("R4", "level high", 32'(v), 32'h01);
        set_pin(9, 1'b0);
        wr(16'h4E5A, 8'hF7);
        rd(16'h4E5A, v); chk("R4", "mode kept, bit0 live", 32'(v), 32'h06);
    endtask

    task automatic t_edges();
        logic [7:0] v;
        do_reset();
        wr(16'h4E53, 8'h04);           // pin 2 rising
        set_pin(2, 1'b1);
        rd(16'h4E0B, v); chk("R5", "rise seen", 32'(v), 32'h04);
        wr(16'h4E0B, 8'h04);
        set_pin(2, 1'b0);
        rd(16'h4E0B, v); chk("R5", "rise ignores fall", 32'(v), 0);
        wr(16'h4E53, 8'h02);           // falling
        set_pin(2, 1'b1);
        rd(16'h4E0B, v); chk("R5", "fall ignores rise", 32'(v), 0);
        set_pin(2, 1'b0);
        rd(16'h4E0B, v); chk("R5", "fall seen", 32'(v), 32'h04);
        wr(16'h4E0B, 8'h04);
        wr(16'h4E53, 8'h06);           // both
        set_pin(2, 1'b1);
        rd(16'h4E0B, v); chk("R5", "both rise", 32'(v), 32'h04);
        wr(16'h4E0B, 8'h04);
        set_pin(2, 1'b0);
        rd(16'h4E0B, v); chk("R5", "both fall", 32'(v), 32'h04);
        wr(16'h4E0B, 8'h04);
        wr(16'h4E53, 8'h00);           // off
        set_pin(2, 1'b1);
        set_pin(2, 1'b0);
        rd(16'h4E0B, v); chk("R5", "off", 32'(v), 0);
    endtask

    task automatic t_groups();
        logic [7:0] s0, s1;
        do_reset();
        wr(16'h4E5C, 8'h04);           // pin 11 rising
        wr(16'h4E57, 8'h04);           // pin 6 rising
        set_pin(11, 1'b1);
        rd(16'h4E0B, s0); rd(16'h4E0C, s1);
        chk("R6", "pin11 group1 bit4", 32'(s1), 32'h10);
        chk("R6", "group0 untouched", 32'(s0), 0);
        set_pin(6, 1'b1);
        rd(16'h4E0B, s0); rd(16'h4E0C, s1);
        chk("R6", "pending vector", 32'({s1[5:0], s0[6:0]}), 32'h0840);
        wr(16'h4E1A, 8'hFF);
        rd(16'h4E1A, s1); chk("R6", "mask1 width", 32'(s1), 32'h3F);
    endtask

    task automatic t_w1c();
        logic [7:0] v;
        do_reset();
        wr(16'h4E53, 8'h06);           // pin 2 both
        wr(16'h4E57, 8'h06);           // pin 6 both
        set_pin(2, 1'b1);
        set_pin(6, 1'b1);
        wr(16'h4E0B, 8'h00);
        rd(16'h4E0B, v); chk("R7", "write zero keeps", 32'(v), 32'h44);
        wr(16'h4E0B, 8'h40);
        rd(16'h4E0B, v); chk("R7", "clear one bit", 32'(v), 32'h04);
        // edge reaches status on the third edge after the pin change
        @(negedge clk); pin_in[2] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 16'h4E0B; bus_wdata = 8'h04; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        rd(16'h4E0B, v); chk("R7", "edge beats clear", 32'(v), 32'h04);
        wr(16'h4E0B, 8'h04);
        rd(16'h4E0B, v); chk("R7", "later clear", 32'(v), 0);
    endtask

    task automatic t_mask();
        logic [7:0] v;
        do_reset();
        wr(16'h4E59, 8'h04);           // pin 8 rising
        wr(16'h4E51, 8'h04);           // pin 0 rising
        set_pin(8, 1'b1);
        rd(16'h4E0C, v); chk("R8", "masked still latched", 32'(v), 32'h02);
        chk("R8", "masked no irq", 32'(irq), 0);
        wr(16'h4E1A, 8'h3D);
        chk("R8", "unmask raises irq", 32'(irq), 1);
        wr(16'h4E19, 8'h7E);
        set_pin(0, 1'b1);
        wr(16'h4E0C, 8'h02);
        chk("R8", "irq held by pin0", 32'(irq), 1);
        wr(16'h4E0B, 8'h01);
        chk("R8", "irq drops", 32'(irq), 0);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        do_reset();
        wr(16'h4E5D, 8'h06);
        rd(16'h4E5E, v); chk("R9", "0x4E5E", 32'(v), 0);
        rd(16'h4E43, v); chk("R9", "0x4E43", 32'(v), 0);
        rd(16'h4E0D, v); chk("R9", "0x4E0D", 32'(v), 0);
        wr(16'h4E5E, 8'hFF);
        wr(16'h4E1B, 8'h00);
        rd(16'h4E5D, v); chk("R9", "neighbour unchanged", 32'(v), 32'h06);
        rd(16'h4E1A, v); chk("R9", "mask1 unchanged", 32'(v), 32'h3F);
    endtask

    initial begin
        t_reset();
        t_outctl();
        t_oe();
        t_level();
        t_edges();
        t_groups();
        t_w1c();
        t_mask();
        t_unmapped();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule